// File: doc/BRIEF.md
# Display Mode Register File

This block holds the configuration of a banked and linear-framebuffer graphics mode. It sits behind a pair of 16-bit ports: the index port picks one of eleven registers and the data port reads or writes the picked register. The stored fields are:

- horizontal and vertical resolution
- colour depth
- bank number
- horizontal and vertical panning offsets
- virtual canvas width and height
- a control word with the enable, capabilities-read, wide-DAC and linear-framebuffer flags

From these fields the block derives four values: the byte count per pixel, the line pitch, the visible area size and the display start address. It drives them straight out to the framebuffer address decoder and to the scan-out engine.

Most writes apply in one cycle. A write to the virtual width is different: it sets off up to three sequential divisions. These fit the virtual canvas into video memory, by raising the height or, when the height would fall below the screen height, by trimming the width. The `busy` output is high from any accepted data write until the derived outputs show the new state. Writes made while `busy` is high are dropped.

Top module: `dispx_regfile`

## Requirements
- R1: After reset the outputs read as follows:
  - horizontal resolution 640, vertical resolution 480 and depth 8
  - virtual size 640×480
  - bank 0, both offsets 0, all flags clear and `bytes_pp` 1
  - pitch 640, visible size 307200 and start 0
  - the identity register reads `ID_BASE`
- R2: A data write to horizontal or vertical resolution is kept only if the mode is disabled and the value does not exceed `MAX_XRES` / `MAX_YRES`. Otherwise the old value stays.
- R3: A depth write of 0 stores 8. Apart from that, only 4, 8, 15, 16, 24 and 32 are stored, and only if the value does not exceed `MAX_BPP`. Depth writes are dropped while the mode is enabled.
- R4: A bank write uses bits 7:0 of the data. It is kept only when that byte is below `MEM_KB/64`, or below `MEM_KB/256` at depth 4, and only while the linear framebuffer flag is clear.
- R5: The control word uses bit 0 for enable, bit 1 for capabilities, bit 5 for wide DAC and bit 6 for the linear framebuffer. When enable rises:
  - virtual width and height take the current resolution
  - both offsets clear
  - the linear framebuffer flag takes bit 6, or 0 at depth 4
  
  Clearing enable also clears the linear framebuffer flag.
- R6: `bytes_pp` is 1, 1, 2, 2, 3, 4 for depths 4, 8, 15, 16, 24, 32. Pitch is virtual width × `bytes_pp`, except at depth 4, where it is virtual width >> 3. Visible size is pitch × vertical resolution.
- R7: While the capabilities flag is set, reads of the two resolution registers and of depth return `MAX_XRES`, `MAX_YRES` and `MAX_BPP`. A read of the control word returns only bits 0, 1 and 5.
- R8: Start address is y offset × pitch + x offset × `bytes_pp`; at depth 4 the second term is x offset >> 3. A y offset write is dropped when y offset × pitch + visible size exceeds the memory limit. The limit is `MEM_KB`×1024 bytes, or a quarter of that at depth 4.
- R9: A nonzero virtual-width write W works as follows:
  - Q = N / `bytes_pp`, where N is the memory size in bytes, or twice that at depth 4.
  - H = Q / W. If H ≥ vertical resolution, the virtual size becomes W × H.
  - Otherwise the height becomes the vertical resolution and the width becomes Q / vertical resolution.
  
  Results above 65535 saturate to 65535. A width write of 0 and all virtual-height writes are ignored.
- R10: Register indices are:

  | Index | Register |
  |---|---|
  | 0 | identity |
  | 1 | horizontal resolution |
  | 2 | vertical resolution |
  | 3 | depth |
  | 4 | control word |
  | 5 | bank |
  | 6 | virtual width |
  | 7 | virtual height |
  | 8 | x offset |
  | 9 | y offset |
  | 10 | memory size |

  `port_sel`=1 addresses the index port, which reads back the index. The identity register keeps only `ID_BASE`..`ID_BASE`+5. The memory-size register reads `MEM_KB` >> 6. Any other index reads 0.
- R11: `busy` is high in the cycle after an accepted data write, and for the whole of a virtual-width computation. When it falls, the derived outputs match the registers. Index and data writes presented while `busy` is high are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_sel | input | 1 | 1 selects the index port, 0 the data port |
| wr_en | input | 1 | Write strobe for the selected port |
| wr_data | input | 16 | Write value |
| rd_data | output | 16 | Read value of the selected port (combinational) |
| busy | output | 1 | Derived outputs are being updated; writes are dropped |
| mode_on | output | 1 | Graphics mode enable flag |
| lin_fb_on | output | 1 | Linear framebuffer flag |
| wide_dac | output | 1 | 8-bit DAC flag |
| bank | output | 8 | Current bank |
| depth | output | 6 | Colour depth in bits |
| bytes_pp | output | 3 | Bytes per pixel |
| xres | output | 16 | Horizontal resolution |
| yres | output | 16 | Vertical resolution |
| virt_w | output | 16 | Virtual canvas width |
| virt_h | output | 16 | Virtual canvas height |
| pitch | output | clog2(MEM_KB·1024)+2 | Line pitch in bytes |
| visible_bytes | output | clog2(MEM_KB·1024)+2 | Visible area size in bytes |
| start_addr | output | clog2(MEM_KB·1024)+2 | Display start byte address |

## Verification
The bench builds the block with `MEM_KB`=1024, `MAX_XRES`=1024, `MAX_YRES`=768 and `MAX_BPP`=32. These values make the bank limits small (16, and 4 at depth 4), so both edges of the bank limit are easy to reach. They also make 32-bit modes larger than memory, so y offsets get rejected. With memory this small, a wide virtual width forces the clamp branch, where the width is recomputed from the screen height. Random modes, offsets and virtual widths are compared against bench functions for pitch, visible size, start and canvas fit.

// File: rtl/dispx_pkg.sv
package dispx_pkg;

   localparam logic [15:0] IX_ID      = 16'd0;
   localparam logic [15:0] IX_XRES    = 16'd1;
   localparam logic [15:0] IX_YRES    = 16'd2;
   localparam logic [15:0] IX_DEPTH   = 16'd3;
   localparam logic [15:0] IX_CTRL    = 16'd4;
   localparam logic [15:0] IX_BANK    = 16'd5;
   localparam logic [15:0] IX_VWIDTH  = 16'd6;
   localparam logic [15:0] IX_VHEIGHT = 16'd7;
   localparam logic [15:0] IX_XOFF    = 16'd8;
   localparam logic [15:0] IX_YOFF    = 16'd9;
   localparam logic [15:0] IX_MEMSZ   = 16'd10;

   localparam int CB_EN   = 0;
   localparam int CB_CAPS = 1;
   localparam int CB_DAC  = 5;
   localparam int CB_LFB  = 6;

   typedef enum logic [2:0] {
      S_IDLE, S_Q1_GO, S_Q1_RUN, S_H_GO, S_H_RUN, S_W_GO, S_W_RUN
   } fit_state_t;

   function automatic logic [2:0] bytes_per_pixel(input logic [5:0] d);
      case (d)
         6'd15, 6'd16: return 3'd2;
         6'd24:        return 3'd3;
         6'd32:        return 3'd4;
         default:      return 3'd1;
      endcase
   endfunction

   function automatic logic depth_legal(input logic [15:0] v, input int max_bpp,
                                        input logic planar_ok);
      logic in_set;
      in_set = (v == 16'd8) || (v == 16'd15) || (v == 16'd16) ||
               (v == 16'd24) || (v == 16'd32) || (planar_ok && v == 16'd4);
      return in_set && (int'(v) <= max_bpp);
   endfunction

endpackage

// File: rtl/dispx_divider.sv
module dispx_divider #(
   parameter int NUM_W = 24,
   parameter int DEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic [NUM_W-1:0] quot,
   output logic             done,
   output logic             running
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   logic [NUM_W-1:0] q_q;
   logic [DEN_W-1:0] r_q, d_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q, done_q;
   logic [DEN_W:0]   trial, diff;
   logic             ge;

   assign trial = {r_q, q_q[NUM_W-1]};
   assign ge    = trial >= {1'b0, d_q};
   assign diff  = trial - {1'b0, d_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_q <= '0; r_q <= '0; d_q <= '0; cnt_q <= '0;
         run_q <= 1'b0; done_q <= 1'b0;
      end else if (go) begin
         q_q <= num; r_q <= '0; d_q <= den;
         cnt_q <= CNT_W'(NUM_W);
         run_q <= 1'b1; done_q <= 1'b0;
      end else if (run_q) begin
         q_q   <= {q_q[NUM_W-2:0], ge};
         r_q   <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == CNT_W'(1)) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
         end
      end else begin
         done_q <= 1'b0;
      end
   end

   assign quot    = q_q;
   assign done    = done_q;
   assign running = run_q;

   // R9: one division at a time, result announced for a single cycle
   p_div_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !run_q);
   p_div_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
endmodule

// File: rtl/dispx_geometry.sv
module dispx_geometry #(
   parameter int  WIDE      = 40,
   parameter bit  PLANAR_EN = 1'b1
) (
   input  logic [5:0]      depth,
   input  logic [15:0]     vw,
   input  logic [15:0]     yres,
   input  logic [15:0]     xoff,
   input  logic [15:0]     yoff,
   output logic [2:0]      bpp,
   output logic [WIDE-1:0] pitch,
   output logic [WIDE-1:0] vis,
   output logic [WIDE-1:0] start
);
   import dispx_pkg::*;

   logic [WIDE-1:0] xterm;

   assign bpp = bytes_per_pixel(depth);

   generate
      if (PLANAR_EN) begin : g_planar
         logic planar;
         assign planar = (depth == 6'd4);
         assign pitch  = planar ? WIDE'(vw >> 3) : WIDE'(vw) * WIDE'(bpp);
         assign xterm  = planar ? WIDE'(xoff >> 3) : WIDE'(xoff) * WIDE'(bpp);
      end else begin : g_packed
         assign pitch = WIDE'(vw) * WIDE'(bpp);
         assign xterm = WIDE'(xoff) * WIDE'(bpp);
      end
   endgenerate

   assign vis   = pitch * WIDE'(yres);
   assign start = WIDE'(yoff) * pitch + xterm;
endmodule

// File: rtl/dispx_regfile.sv
module dispx_regfile #(
   parameter int          MAX_XRES  = 1600,
   parameter int          MAX_YRES  = 1200,
   parameter int          MAX_BPP   = 32,
   parameter int          MEM_KB    = 8192,
   parameter logic [15:0] ID_BASE   = 16'hD150,
   parameter int          ID_COUNT  = 6,
   parameter bit          PLANAR_EN = 1'b1,
   localparam int         ADDR_W    = $clog2(MEM_KB * 1024) + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_sel,
   input  logic              wr_en,
   input  logic [15:0]       wr_data,
   output logic [15:0]       rd_data,
   output logic              busy,
   output logic              mode_on,
   output logic              lin_fb_on,
   output logic              wide_dac,
   output logic [7:0]        bank,
   output logic [5:0]        depth,
   output logic [2:0]        bytes_pp,
   output logic [15:0]       xres,
   output logic [15:0]       yres,
   output logic [15:0]       virt_w,
   output logic [15:0]       virt_h,
   output logic [ADDR_W-1:0] pitch,
   output logic [ADDR_W-1:0] visible_bytes,
   output logic [ADDR_W-1:0] start_addr
);
   import dispx_pkg::*;

   localparam int MEM_BYTES = MEM_KB * 1024;
   localparam int WIDE      = 40;
   localparam logic [ADDR_W-1:0] NUM_STD = ADDR_W'(MEM_BYTES);
   localparam logic [ADDR_W-1:0] NUM_PLN = ADDR_W'(2 * MEM_BYTES);
   localparam logic [WIDE-1:0]   LIM_STD = WIDE'(MEM_BYTES);
   localparam logic [WIDE-1:0]   LIM_PLN = WIDE'(MEM_BYTES / 4);
   localparam logic [15:0]       BANK_STD = 16'(MEM_KB / 64);
   localparam logic [15:0]       BANK_PLN = 16'(MEM_KB / 256);

   generate
      if (MEM_KB < 256 || (MEM_KB % 256) != 0) begin : g_bad_mem
         $error("MEM_KB must be a multiple of 256");
      end
      if (MAX_BPP < 8 || MAX_BPP > 32) begin : g_bad_bpp
         $error("MAX_BPP out of range");
      end
      if (MAX_XRES > 65535 || MAX_YRES > 65535) begin : g_bad_res
         $error("resolution limits exceed 16 bits");
      end
      if (ID_COUNT < 1 || int'(ID_BASE) + ID_COUNT > 65536) begin : g_bad_id
         $error("identity range invalid");
      end
   endgenerate

   logic [15:0] idx_q, id_q, xres_q, yres_q, vw_q, vh_q, xoff_q, yoff_q, wreq_q;
   logic [5:0]  depth_q;
   logic [7:0]  bank_q;
   logic        en_q, caps_q, dac_q, lfb_q, dirty_q;
   fit_state_t  st_q;
   logic [ADDR_W-1:0] q1_q, pitch_q, vis_q, start_q;

   logic [2:0]        g_bpp;
   logic [WIDE-1:0]   g_pitch, g_vis, g_start, y_need;
   logic              planar, wr_ok, data_wr, index_wr, y_ok, bank_ok, id_ok;
   logic              div_go, div_done, div_run, fit_fin;
   logic [ADDR_W-1:0] div_num, div_quot;
   logic [15:0]       div_den, quot_sat;

   dispx_geometry #(.WIDE(WIDE), .PLANAR_EN(PLANAR_EN)) u_geom (
      .depth(depth_q), .vw(vw_q), .yres(yres_q), .xoff(xoff_q), .yoff(yoff_q),
      .bpp(g_bpp), .pitch(g_pitch), .vis(g_vis), .start(g_start));

   dispx_divider #(.NUM_W(ADDR_W), .DEN_W(16)) u_div (
      .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(div_den),
      .quot(div_quot), .done(div_done), .running(div_run));

   assign planar   = PLANAR_EN && (depth_q == 6'd4);
   assign busy     = (st_q != S_IDLE) || dirty_q;
   assign wr_ok    = wr_en && !busy;
   assign data_wr  = wr_ok && !port_sel;
   assign index_wr = wr_ok && port_sel;
   assign y_need   = WIDE'(wr_data) * g_pitch + g_vis;
   assign y_ok     = y_need <= (planar ? LIM_PLN : LIM_STD);
   assign bank_ok  = {8'd0, wr_data[7:0]} < (planar ? BANK_PLN : BANK_STD);
   assign id_ok    = (wr_data - ID_BASE) < 16'(ID_COUNT);
   assign div_go   = (st_q == S_Q1_GO) || (st_q == S_H_GO) || (st_q == S_W_GO);
   assign quot_sat = (|div_quot[ADDR_W-1:16]) ? 16'hFFFF : div_quot[15:0];
   assign fit_fin  = div_done && ((st_q == S_W_RUN) ||
                     (st_q == S_H_RUN && div_quot >= ADDR_W'(yres_q)));

   always_comb begin
      case (st_q)
         S_Q1_GO, S_Q1_RUN: begin
            div_num = planar ? NUM_PLN : NUM_STD;
            div_den = {13'd0, g_bpp};
         end
         S_H_GO, S_H_RUN: begin
            div_num = q1_q;
            div_den = wreq_q;
         end
         default: begin
            div_num = q1_q;
            div_den = yres_q;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0; id_q <= ID_BASE;
         xres_q <= 16'd640; yres_q <= 16'd480; vw_q <= 16'd640; vh_q <= 16'd480;
         xoff_q <= '0; yoff_q <= '0; wreq_q <= '0; depth_q <= 6'd8; bank_q <= '0;
         en_q <= 1'b0; caps_q <= 1'b0; dac_q <= 1'b0; lfb_q <= 1'b0;
         dirty_q <= 1'b1; st_q <= S_IDLE; q1_q <= '0;
      end else begin
         dirty_q <= data_wr || fit_fin;
         if (index_wr) idx_q <= wr_data;
         if (data_wr) begin
            case (idx_q)
               IX_ID:    if (id_ok) id_q <= wr_data;
               IX_XRES:  if (!en_q && int'(wr_data) <= MAX_XRES) xres_q <= wr_data;
               IX_YRES:  if (!en_q && int'(wr_data) <= MAX_YRES) yres_q <= wr_data;
               IX_DEPTH: begin
                  if (!en_q && wr_data == 16'd0) depth_q <= 6'd8;
                  else if (!en_q && depth_legal(wr_data, MAX_BPP, PLANAR_EN))
                     depth_q <= wr_data[5:0];
               end
               IX_BANK:  if (bank_ok && !lfb_q) bank_q <= wr_data[7:0];
               IX_CTRL: begin
                  if (wr_data[CB_EN] && !en_q) begin
                     vw_q <= xres_q; vh_q <= yres_q;
                     xoff_q <= '0; yoff_q <= '0;
                     lfb_q <= wr_data[CB_LFB] && !planar;
                  end else if (!wr_data[CB_EN]) begin
                     lfb_q <= 1'b0;
                  end
                  en_q   <= wr_data[CB_EN];
                  caps_q <= wr_data[CB_CAPS];
                  dac_q  <= wr_data[CB_DAC];
               end
               IX_VWIDTH: if (wr_data != 16'd0) begin
                  wreq_q <= wr_data;
                  st_q   <= S_Q1_GO;
               end
               IX_XOFF:  xoff_q <= wr_data;
               IX_YOFF:  if (y_ok) yoff_q <= wr_data;
               default: ;
            endcase
         end
         case (st_q)
            S_Q1_GO: st_q <= S_Q1_RUN;
            S_H_GO:  st_q <= S_H_RUN;
            S_W_GO:  st_q <= S_W_RUN;
            S_Q1_RUN: if (div_done) begin
               q1_q <= div_quot;
               st_q <= S_H_GO;
            end
            S_H_RUN: if (div_done) begin
               if (div_quot >= ADDR_W'(yres_q)) begin
                  vw_q <= wreq_q; vh_q <= quot_sat; st_q <= S_IDLE;
               end else begin
                  vh_q <= yres_q; st_q <= S_W_GO;
               end
            end
            S_W_RUN: if (div_done) begin
               vw_q <= quot_sat; st_q <= S_IDLE;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pitch_q <= '0; vis_q <= '0; start_q <= '0;
      end else begin
         pitch_q <= g_pitch[ADDR_W-1:0];
         vis_q   <= g_vis[ADDR_W-1:0];
         start_q <= g_start[ADDR_W-1:0];
      end
   end

   always_comb begin
      rd_data = '0;
      if (port_sel) rd_data = idx_q;
      else begin
         case (idx_q)
            IX_ID:      rd_data = id_q;
            IX_XRES:    rd_data = caps_q ? 16'(MAX_XRES) : xres_q;
            IX_YRES:    rd_data = caps_q ? 16'(MAX_YRES) : yres_q;
            IX_DEPTH:   rd_data = caps_q ? 16'(MAX_BPP) : {10'd0, depth_q};
            IX_CTRL: begin
               rd_data[CB_EN]   = en_q;
               rd_data[CB_CAPS] = caps_q;
               rd_data[CB_DAC]  = dac_q;
            end
            IX_BANK:    rd_data = {8'd0, bank_q};
            IX_VWIDTH:  rd_data = vw_q;
            IX_VHEIGHT: rd_data = vh_q;
            IX_XOFF:    rd_data = xoff_q;
            IX_YOFF:    rd_data = yoff_q;
            IX_MEMSZ:   rd_data = 16'(MEM_KB >> 6);
            default:    rd_data = '0;
         endcase
      end
   end

   assign mode_on = en_q;  assign lin_fb_on = lfb_q;  assign wide_dac = dac_q;
   assign bank = bank_q;   assign depth = depth_q;    assign bytes_pp = g_bpp;
   assign xres = xres_q;   assign yres = yres_q;
   assign virt_w = vw_q;   assign virt_h = vh_q;
   assign pitch = pitch_q; assign visible_bytes = vis_q; assign start_addr = start_q;

   p_res_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> $stable(xres_q) && $stable(yres_q));
   p_depth_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> $stable(depth_q));
   p_bank_lfb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lfb_q |=> $stable(bank_q));
   p_bank_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
      {8'd0, bank_q} < BANK_STD);
   p_enable_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q) |-> (vw_q == $past(xres_q)) && (xoff_q == 16'd0) && (yoff_q == 16'd0));
   p_lfb_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lfb_q |-> en_q && !planar);
   p_fit_height_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fit_fin |=> vh_q >= yres_q);
   p_busy_index_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(idx_q));
   p_fit_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      div_run |-> busy);
endmodule

// File: tb/tb_dispx_regfile.sv
module tb_dispx_regfile;
   localparam int MAX_X = 1024, MAX_Y = 768, MAX_B = 32, MEM_KB = 1024;
   localparam int MEM = MEM_KB * 1024;
   localparam int AW = $clog2(MEM) + 2;
   localparam longint MASK = (64'd1 << AW) - 1;
   localparam logic [15:0] IDB = 16'hD150;

   logic clk = 1'b0, rst_n = 1'b0, port_sel = 1'b0, wr_en = 1'b0;
   logic [15:0] wr_data = '0, rd_data, xres, yres, virt_w, virt_h;
   logic busy, mode_on, lin_fb_on, wide_dac;
   logic [7:0] bank; logic [5:0] depth; logic [2:0] bytes_pp;
   logic [AW-1:0] pitch, visible_bytes, start_addr;
   int n_cmp = 0, n_bad = 0;

   always #5 clk = ~clk;

   dispx_regfile #(.MAX_XRES(MAX_X), .MAX_YRES(MAX_Y), .MAX_BPP(MAX_B),
                   .MEM_KB(MEM_KB), .ID_BASE(IDB)) dut (
      .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .busy(busy), .mode_on(mode_on), .lin_fb_on(lin_fb_on),
      .wide_dac(wide_dac), .bank(bank), .depth(depth), .bytes_pp(bytes_pp),
      .xres(xres), .yres(yres), .virt_w(virt_w), .virt_h(virt_h), .pitch(pitch),
      .visible_bytes(visible_bytes), .start_addr(start_addr));

   task automatic chk(input string tag, input longint got, input longint exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic put(input logic sel, input logic [15:0] v);
      @(negedge clk);
      while (busy) @(negedge clk);
      port_sel = sel; wr_data = v; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      while (busy) @(negedge clk);
   endtask

   task automatic wreg(input logic [15:0] ix, input logic [15:0] v);
      put(1'b1, ix); put(1'b0, v);
   endtask

   task automatic rreg(input logic [15:0] ix, output logic [15:0] v);
      put(1'b1, ix);
      port_sel = 1'b0; #1; v = rd_data;
   endtask

   function automatic int bpp_of(input int d);
      case (d) 15, 16: return 2; 24: return 3; 32: return 4; default: return 1; endcase
   endfunction

   function automatic longint pitch_of(input int d, input int w);
      return (d == 4) ? longint'(w >> 3) : longint'(w) * bpp_of(d);
   endfunction

   function automatic int sat16(input longint v);
      return (v > 65535) ? 65535 : int'(v);
   endfunction

   // R9 model: returns {width, height}
   function automatic longint fit_model(input int d, input int w, input int y);
      longint q1, h;
      q1 = ((d == 4) ? 2 * longint'(MEM) : longint'(MEM)) / bpp_of(d);
      h  = q1 / w;
      if (h >= y) return (longint'(w) << 16) | sat16(h);
      return (longint'(sat16(q1 / y)) << 16) | y;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'd2718));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 reset state
      chk("R1 xres", xres, 640);           chk("R1 yres", yres, 480);
      chk("R1 depth", depth, 8);            chk("R1 virt_w", virt_w, 640);
      chk("R1 virt_h", virt_h, 480);        chk("R1 pitch", pitch, 640);
      chk("R1 visible", visible_bytes, 307200);
      chk("R1 start", start_addr, 0);       chk("R1 mode_on", mode_on, 0);
      chk("R1 bytes_pp", bytes_pp, 1);      chk("R1 bank", bank, 0);
      rreg(16'd0, v); chk("R1 id", v, IDB);

      // R2 resolution limits and lock
      wreg(16'd1, 16'd800);  chk("R2 xres accept", xres, 800);
      wreg(16'd1, 16'd1025); chk("R2 xres over max", xres, 800);
      wreg(16'd2, 16'd600);  chk("R2 yres accept", yres, 600);
      wreg(16'd2, 16'd769);  chk("R2 yres over max", yres, 600);
      wreg(16'd4, 16'h0001);
      wreg(16'd1, 16'd320);  chk("R2 xres locked", xres, 800);
      wreg(16'd3, 16'd16);   chk("R3 depth locked", depth, 8);
      wreg(16'd4, 16'h0000);

      // R3 depth coding
      wreg(16'd3, 16'd24); wreg(16'd3, 16'd0); chk("R3 zero means 8", depth, 8);
      wreg(16'd3, 16'd12); chk("R3 illegal depth", depth, 8);
      wreg(16'd3, 16'd24); chk("R3 depth 24", depth, 24);
      wreg(16'd3, 16'd64); chk("R3 above max", depth, 24);
      wreg(16'd3, 16'd8);

      // R4 bank
      wreg(16'd5, 16'h0305); chk("R4 low byte", bank, 5);
      wreg(16'd5, 16'd16);   chk("R4 bank limit", bank, 5);
      wreg(16'd5, 16'd15);   chk("R4 bank top", bank, 15);
      wreg(16'd3, 16'd4);
      wreg(16'd5, 16'd3);    chk("R4 planar bank", bank, 3);
      wreg(16'd5, 16'd4);    chk("R4 planar limit", bank, 3);
      wreg(16'd3, 16'd8);
      wreg(16'd4, 16'h0041);
      wreg(16'd5, 16'd7);    chk("R4 lfb lock", bank, 3);
      wreg(16'd4, 16'h0000); chk("R5 disable clears lfb", lin_fb_on, 0);

      // R5 enable rise
      wreg(16'd3, 16'd16); wreg(16'd8, 16'd5); wreg(16'd9, 16'd2);
      wreg(16'd4, 16'h0041);
      chk("R5 virt_w copy", virt_w, 800);   chk("R5 virt_h copy", virt_h, 600);
      rreg(16'd8, v); chk("R5 xoff clear", v, 0);
      rreg(16'd9, v); chk("R5 yoff clear", v, 0);
      chk("R5 lfb", lin_fb_on, 1);          chk("R6 bytes_pp 16", bytes_pp, 2);
      chk("R6 pitch", pitch, 1600);         chk("R6 visible", visible_bytes, 960000);
      chk("R8 start after enable", start_addr, 0);

      // R7 capabilities
      wreg(16'd4, 16'h0023);
      rreg(16'd1, v); chk("R7 caps xres", v, MAX_X);
      rreg(16'd2, v); chk("R7 caps yres", v, MAX_Y);
      rreg(16'd3, v); chk("R7 caps depth", v, MAX_B);
      rreg(16'd4, v); chk("R7 ctrl read", v, 16'h0023);
      chk("R7 wide_dac", wide_dac, 1);
      wreg(16'd4, 16'h0001);
      rreg(16'd1, v); chk("R7 caps off", v, 800);

      // R8 start address and y limit
      wreg(16'd9, 16'd50); wreg(16'd8, 16'd10);
      chk("R8 start", start_addr, 50 * 1600 + 20);
      wreg(16'd9, 16'd60);
      rreg(16'd9, v); chk("R8 y reject", v, 50);

      // R9 virtual canvas fit
      wreg(16'd6, 16'd1024);
      chk("R9 clamp height", virt_h, 600); chk("R9 clamp width", virt_w, 873);
      wreg(16'd6, 16'd400);
      chk("R9 width", virt_w, 400);        chk("R9 height", virt_h, 1310);
      wreg(16'd7, 16'd5);  chk("R9 vheight ignored", virt_h, 1310);
      wreg(16'd6, 16'd0);  chk("R9 zero width", virt_w, 400);
      wreg(16'd6, 16'd1);  chk("R9 saturate", virt_h, 65535);

      // R10 identity, memory size, unknown index
      wreg(16'd0, IDB + 16'd3); rreg(16'd0, v); chk("R10 id accept", v, IDB + 3);
      wreg(16'd0, IDB + 16'd6); rreg(16'd0, v); chk("R10 id reject", v, IDB + 3);
      rreg(16'd10, v); chk("R10 mem size", v, MEM_KB >> 6);
      rreg(16'd13, v); chk("R10 unknown", v, 0);
      port_sel = 1'b1; #1; chk("R10 index read", rd_data, 13);

      // R11 writes while busy are dropped
      put(1'b1, 16'd8);
      @(negedge clk); port_sel = 1'b0; wr_data = 16'd7; wr_en = 1'b1;
      @(negedge clk); port_sel = 1'b1; wr_data = 16'd5;
      chk("R11 busy after write", busy, 1);
      @(negedge clk); wr_en = 1'b0;
      while (busy) @(negedge clk);
      port_sel = 1'b1; #1; chk("R11 index kept", rd_data, 8);

      // random modes, R6 R8 R9
      for (int it = 0; it < 24; it++) begin
         int d, x, y, xo, yo, b;
         longint p, vis, fm;
         logic [15:0] yv;
         case ($urandom % 6)
            0: d = 4; 1: d = 8; 2: d = 15; 3: d = 16; 4: d = 24; default: d = 32;
         endcase
         x = 1 + int'($urandom % MAX_X);
         y = 1 + int'($urandom % MAX_Y);
         wreg(16'd4, 16'h0000);
         wreg(16'd1, 16'(x)); wreg(16'd2, 16'(y)); wreg(16'd3, 16'(d));
         wreg(16'd4, 16'h0041);
         b = bpp_of(d); p = pitch_of(d, x); vis = p * y;
         chk("R5 rnd virt_w", virt_w, x);
         chk("R5 rnd lfb", lin_fb_on, (d != 4) ? 1 : 0);
         chk("R6 rnd bytes_pp", bytes_pp, b);
         chk("R6 rnd pitch", pitch, p & MASK);
         chk("R6 rnd visible", visible_bytes, vis & MASK);
         xo = int'($urandom % 512); yo = int'($urandom % 64);
         wreg(16'd8, 16'(xo)); wreg(16'd9, 16'(yo));
         if (longint'(yo) * p + vis > ((d == 4) ? MEM / 4 : MEM)) yo = 0;
         rreg(16'd9, yv); chk("R8 rnd yoff", yv, yo);
         chk("R8 rnd start", start_addr,
             (longint'(yo) * p + ((d == 4) ? (xo >> 3) : xo * b)) & MASK);
         begin
            int w;
            w = 1 + int'($urandom % 2048);
            wreg(16'd6, 16'(w));
            fm = fit_model(d, w, y);
            chk("R9 rnd width", virt_w, fm >> 16);
            chk("R9 rnd height", virt_h, fm & 16'hFFFF);
            chk("R6 rnd pitch after fit", pitch, pitch_of(d, int'(fm >> 16)) & MASK);
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule